// File: doc/BRIEF.md
# Shared-Bus Word Memory with Address Latch

This block is a word-addressed random-access memory that sits on a single 16-bit bus used for both addresses and data. Since the bus can carry only one value per cycle, an access takes two steps. First an address is placed on the bus and captured into an internal address latch by its own load strobe. The latch then keeps that address while the bus is reused. In a later cycle a write strobe stores the bus word into the addressed cell, or a read strobe makes that cell drive its contents onto the bus.

The latched address selects a cell by crossing two one-hot decodes. The upper half of the decoded address bits picks a row and the lower half picks a column. Each cell gates its own write and read by the AND of its row select, its column select and the global strobe. Every cell that is not selected contributes zero to the output, and so does the whole array while the read strobe is low. The output can therefore be OR-ed with other bus sources. The number of row (and column) bits is a parameter. With 8 bits per half the array covers the full 64K-word space. The default is 4 bits per half, which gives a 256-word array in which the address bits above the decoded ones are ignored.

Top module: `single_bus_ram`

## Requirements
- R1: On a rising clock edge with `addr_load` high, the address latch takes the value of `bus_in`.
- R2: While `addr_load` is low, the address latch keeps its value, so later values on `bus_in` do not change which cell is targeted.
- R3: On a rising clock edge with `mem_write` high, the cell selected by the latched address stores `bus_in`, and every other cell keeps its contents.
- R4: While `mem_read` is high, `bus_out` equals the stored word of the selected cell in the same cycle, with no clock edge in between.
- R5: While `mem_read` is low, `bus_out` is all zeros, whatever the contents of the array or the value on `bus_in`.
- R6: The row index is latched address bits [2*HALF_BITS-1:HALF_BITS] and the column index is bits [HALF_BITS-1:0]. Exactly one row select and one column select are active. Bits above 2*HALF_BITS-1 are ignored, so with the default (HALF_BITS=4) the address 0x1234 reaches the same cell as 0x0034.
- R7: When `addr_load` and `mem_write` are high in the same cycle, the write goes to the address held before that edge, and the latch then takes `bus_in`.
- R8: After reset, the address latch is zero and every cell reads as zero.
- R9: When `mem_write` and `mem_read` are high in the same cycle, `bus_out` shows the word stored before that edge. The new word is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Strobes are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 16 | Shared bus value, carrying either an address or data |
| bus_out | output | 16 | This block's contribution to the bus. It is zero unless reading |
| addr_load | input | 1 | Loads the address latch from `bus_in` |
| mem_write | input | 1 | Writes `bus_in` into the selected cell |
| mem_read | input | 1 | Drives the selected cell onto `bus_out` |

## Verification
A read result is due in the same cycle as its strobe, because `bus_out` is combinational from the stored cell. The bench raises `mem_read` just after a falling edge and samples 1 ns later, well before the next rising edge. A change to the address latch or a write takes effect at the rising edge that samples its strobe. The bench therefore updates its reference model at that edge and observes the result only in a later read phase. Each same-cycle case (R7, R9) is sampled before the edge that commits it, and again in the following cycle.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    localparam int BUS_W = 16;
    typedef logic [BUS_W-1:0] word_t;
endpackage

// File: rtl/sbr_addr_latch.sv
module sbr_addr_latch
    import sbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  word_t d,
    output word_t q
);
    // Bus-loaded register: holds indefinitely while load is low
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/sbr_onehot_dec.sv
module sbr_onehot_dec #(
    parameter int IN_W = 4
) (
    input  logic [IN_W-1:0]      code,
    output logic [(1<<IN_W)-1:0] sel
);
    localparam int OUTS = 1 << IN_W;

    // One comparator per output line
    for (genvar i = 0; i < OUTS; i++) begin : g_line
        assign sel[i] = (code == IN_W'(i));
    end
endmodule

// File: rtl/sbr_cell.sv
module sbr_cell
    import sbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  row_hit,
    input  logic  col_hit,
    input  logic  wr_strobe,
    input  logic  rd_strobe,
    input  word_t d,
    output word_t q_gated
);
    word_t store_q;
    logic  wr_en;
    logic  rd_en;

    // Per-cell gating: row AND column AND global strobe
    assign wr_en = row_hit & col_hit & wr_strobe;
    assign rd_en = row_hit & col_hit & rd_strobe;

    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (wr_en)
            store_q <= d;
    end

    // A cell that is not driving contributes zeros
    assign q_gated = rd_en ? store_q : '0;
endmodule

// File: rtl/single_bus_ram.sv
module single_bus_ram
    import sbr_pkg::*;
#(
    parameter int HALF_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [BUS_W-1:0]  bus_out,
    input  logic              addr_load,
    input  logic              mem_write,
    input  logic              mem_read
);
    localparam int LINES = 1 << HALF_BITS;
    localparam int IDX_W = 2 * HALF_BITS;
    localparam int CELLS = LINES * LINES;

    word_t                 mar_q;
    logic [HALF_BITS-1:0]  row_code;
    logic [HALF_BITS-1:0]  col_code;
    logic [LINES-1:0]      row_sel;
    logic [LINES-1:0]      col_sel;
    word_t                 cell_rd [CELLS];
    word_t                 merged;

    sbr_addr_latch u_mar (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (addr_load),
        .d     (bus_in),
        .q     (mar_q)
    );

    assign row_code = mar_q[IDX_W-1:HALF_BITS];
    assign col_code = mar_q[HALF_BITS-1:0];

    sbr_onehot_dec #(.IN_W(HALF_BITS)) u_row_dec (
        .code (row_code),
        .sel  (row_sel)
    );

    sbr_onehot_dec #(.IN_W(HALF_BITS)) u_col_dec (
        .code (col_code),
        .sel  (col_sel)
    );

    for (genvar r = 0; r < LINES; r++) begin : g_row
        for (genvar c = 0; c < LINES; c++) begin : g_col
            sbr_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .row_hit   (row_sel[r]),
                .col_hit   (col_sel[c]),
                .wr_strobe (mem_write),
                .rd_strobe (mem_read),
                .d         (bus_in),
                .q_gated   (cell_rd[r*LINES+c])
            );
        end
    end

    // Wired-OR of all cell contributions; at most one is nonzero
    always_comb begin
        merged = '0;
        for (int k = 0; k < CELLS; k++)
            merged = merged | cell_rd[k];
    end

    assign bus_out = merged;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
    import sbr_pkg::*;
#(
    parameter int HALF_BITS = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [BUS_W-1:0]         bus_in,
    input logic [BUS_W-1:0]         bus_out,
    input logic                     addr_load,
    input logic                     mem_write,
    input logic                     mem_read,
    input logic [BUS_W-1:0]         mar,
    input logic [(1<<HALF_BITS)-1:0] row_sel,
    input logic [(1<<HALF_BITS)-1:0] col_sel
);
    localparam int IDX_W = 2 * HALF_BITS;

    assert_mar_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (mar == $past(bus_in)));

    assert_mar_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_load |=> $stable(mar));

    assert_write_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mem_write) && !$past(mem_read) && mem_read &&
         (mar[IDX_W-1:0] == $past(mar[IDX_W-1:0]))) |-> (bus_out == $past(bus_in)));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_read |-> (bus_out == '0));

    assert_one_cross_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(row_sel) == 1) && ($countones(col_sel) == 1) &&
        row_sel[mar[IDX_W-1:HALF_BITS]] && col_sel[mar[HALF_BITS-1:0]]);
endmodule

bind single_bus_ram sbr_checker #(.HALF_BITS(HALF_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .addr_load (addr_load),
    .mem_write (mem_write),
    .mem_read  (mem_read),
    .mar       (mar_q),
    .row_sel   (row_sel),
    .col_sel   (col_sel)
);

// File: tb/sim_single_bus_ram.sv
`timescale 1ns/1ps
module sim_single_bus_ram;
    localparam int HALF = 4;
    localparam int IDXW = 2 * HALF;
    localparam int NCELL = 1 << IDXW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        addr_load = 1'b0;
    logic        mem_write = 1'b0;
    logic        mem_read = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] mdl [NCELL];
    logic [15:0] mar_m;

    always #2.5 clk = ~clk;

    single_bus_ram #(.HALF_BITS(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
        .addr_load(addr_load), .mem_write(mem_write), .mem_read(mem_read)
    );

    function automatic int idx_of(input logic [15:0] a);
        return int'(a[IDXW-1:0]);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each task starts and ends just after a falling edge
    task automatic do_load(input logic [15:0] a);
        bus_in = a; addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0; bus_in = 16'hDEAD;
        mar_m = a;
    endtask

    task automatic do_write(input logic [15:0] d);
        bus_in = d; mem_write = 1'b1;
        @(negedge clk);
        mem_write = 1'b0; bus_in = '0;
        mdl[idx_of(mar_m)] = d;
    endtask

    task automatic do_read(input string req);
        mem_read = 1'b1;
        #1;
        check(req, bus_out, mdl[idx_of(mar_m)]);
        @(negedge clk);
        mem_read = 1'b0;
        #1;
        check("R5", bus_out, 16'h0000);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NCELL; i++) mdl[i] = '0;
        mar_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state, latch at zero reads cell 0
        #1 check("R8", bus_out, 16'h0000);
        do_read("R8");
        do_load(16'h00B7);
        do_read("R8");

        // R3/R4/R6: directed corner addresses
        begin
            logic [15:0] corners [5] = '{16'h0000, 16'h00FF, 16'hFF00, 16'hFFFF, 16'h0203};
            logic [15:0] vals    [5] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h0042};
            for (int i = 0; i < 5; i++) begin
                do_load(corners[i]);
                do_write(vals[i]);
            end
            for (int i = 0; i < 5; i++) begin
                do_load(corners[i]);
                do_read("R3 R4");
            end
        end

        // R2: bus reused between load and write
        do_load(16'h0021);
        bus_in = 16'h00EE; @(negedge clk); bus_in = 16'h0000;
        do_write(16'h5A5A);
        do_read("R2");

        // R5: idle output with activity on bus_in
        bus_in = 16'hFFFF; #1 check("R5", bus_out, 16'h0000);
        @(negedge clk);

        // R6: upper bits ignored, 0x1234 aliases 0x0034
        do_load(16'h1234);
        do_write(16'hC0DE);
        do_load(16'h0034);
        do_read("R6");

        // R7: load and write together use the old address
        do_load(16'h0045);
        bus_in = 16'h0067; addr_load = 1'b1; mem_write = 1'b1;
        @(negedge clk);
        addr_load = 1'b0; mem_write = 1'b0;
        mdl[idx_of(mar_m)] = 16'h0067;
        mar_m = 16'h0067;
        do_read("R7 new latch");
        do_load(16'h0045);
        do_read("R7 old address");

        // R9: write and read together show the old word
        do_load(16'h0099);
        do_write(16'hAAAA);
        bus_in = 16'hBBBB; mem_write = 1'b1; mem_read = 1'b1;
        #1 check("R9 same cycle", bus_out, 16'hAAAA);
        @(negedge clk);
        mem_write = 1'b0;
        mdl[idx_of(mar_m)] = 16'hBBBB;
        #1 check("R9 next cycle", bus_out, 16'hBBBB);
        mem_read = 1'b0;
        @(negedge clk);

        // R1: latch capture checked by reading after random loads
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 2));
            if (op == 0) do_load(16'($urandom()));
            else if (op == 1) do_write(16'($urandom()));
            else do_read("R1 R3 R4 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule